// File: doc/BRIEF.md
# Link Layer Port State Controller

This block holds the port state of a link layer: Down, Initialize, Arm or Active. It takes a few inputs from neighbouring logic. One says whether the physical link is up. Others flag a received flow-control-initialize packet, a received normal flow-control packet and a valid data packet that passed its variant CRC check. There is also a management command and a link-down timeout. From these it decides which state the port is in.

Each state opens or closes four traffic gates: data transmit, data receive, management packets in both directions, and link packet generation and acceptance. Traffic whose gate is closed is dropped by the surrounding logic.

Moving from Arm to Active needs three events in order. First a normal flow-control packet must arrive. Then management must ask for Active. Then a valid data packet must arrive. This keeps the port from going live before the far end is ready. The state and all four gates are registered and change together on the clock edge after the event that causes them.

Top module: `port_state_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the port in Initialize (code 1). With that, the management and link gates are open and both data gates are closed.
- R2: While `phy_up` is low, the port does not leave Initialize or Down, whatever the command. From Arm or Active it falls to Down on the next edge.
- R3: In Down with `phy_up` high, and with no timeout or Down command, the port enters Initialize on the next edge.
- R4: A Down command (`mgmt_cmd` = 1) moves the port to Down on the next edge from any state. The timeout is the only input that ranks above it.
- R5: In Initialize with `phy_up` high, an Arm command (`mgmt_cmd` = 2) moves the port to Arm on the next edge. An Active command (`mgmt_cmd` = 3) there has no effect.
- R6: Arm moves to Active only in a cycle where `act_trigger` is high and two things happened in earlier cycles of the same Arm stay: an `act_enable` pulse, then an Active command. An Active command seen before any `act_enable` is ignored. Both remembered events are cleared when the port leaves Arm.
- R7: `down_timeout` high moves the port to Down on the next edge from any state, ahead of every other input.
- R8: `remote_init` in Arm or Active, with `phy_up` high and no timeout or Down command, sends the port back to Initialize. In Initialize or Down it has no effect.
- R9: The state code is Down=0, Initialize=1, Arm=2, Active=3. The gates per state are:
  - Down: all four closed.
  - Initialize: management and link open.
  - Arm: management, link and data receive open.
  - Active: all four open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_up | input | 1 | Physical link is up |
| remote_init | input | 1 | Flow-control-initialize packet received and checked |
| mgmt_cmd | input | 2 | Management request: 0 none, 1 Down, 2 Arm, 3 Active |
| act_enable | input | 1 | Normal flow-control packet received |
| act_trigger | input | 1 | Valid data packet on a data lane received |
| down_timeout | input | 1 | Link-down timer expired |
| data_tx_en | output | 1 | Data packet transmit gate |
| data_rx_en | output | 1 | Data packet receive gate |
| mgmt_en | output | 1 | Management packet gate, both directions |
| lpkt_en | output | 1 | Link packet gate, generation and acceptance |
| port_state | output | 2 | Current port state code |

## Verification
Any error in the state register shows on `port_state` and on the four gates at the first negative clock edge after the faulty transition, because all five outputs come from the same next-state value. Errors in the hidden Arm bookkeeping cannot be seen until a trigger arrives. If the enable memory or request memory is lost or kept too long, the mistake shows up one cycle after the next `act_trigger`, as Active reached too early or not at all. The bench therefore builds trigger sequences with the enable and command in each order, and leaves Arm between them, so that stale bookkeeping is exposed.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int STATE_W = 2;
  localparam int CMD_W   = 2;
  localparam int GATE_N  = 4;

  typedef enum logic [STATE_W-1:0] {
    PS_DOWN   = 2'd0,
    PS_INIT   = 2'd1,
    PS_ARM    = 2'd2,
    PS_ACTIVE = 2'd3
  } pstate_e;

  typedef enum logic [CMD_W-1:0] {
    MC_NONE   = 2'd0,
    MC_DOWN   = 2'd1,
    MC_ARM    = 2'd2,
    MC_ACTIVE = 2'd3
  } mcmd_e;

  typedef struct packed {
    logic data_tx;
    logic data_rx;
    logic mgmt;
    logic lpkt;
  } gate_t;

  function automatic gate_t gates_for(pstate_e s);
    gate_t g;
    g.data_tx = (s == PS_ACTIVE);
    g.data_rx = (s == PS_ARM) || (s == PS_ACTIVE);
    g.mgmt    = (s != PS_DOWN);
    g.lpkt    = (s != PS_DOWN);
    return g;
  endfunction
endpackage

// File: rtl/pls_next.sv
module pls_next
  import pls_pkg::*;
(
  input  pstate_e state,
  input  logic    phy_up,
  input  logic    remote_init,
  input  mcmd_e   cmd,
  input  logic    timeout,
  input  logic    go_active,
  output pstate_e nxt
);
  always_comb begin
    nxt = state;
    if (timeout) begin
      nxt = PS_DOWN;
    end else if (cmd == MC_DOWN) begin
      nxt = PS_DOWN;
    end else if (!phy_up) begin
      if (state == PS_ARM || state == PS_ACTIVE) nxt = PS_DOWN;
    end else begin
      unique case (state)
        PS_DOWN:   nxt = PS_INIT;
        PS_INIT:   if (cmd == MC_ARM) nxt = PS_ARM;
        PS_ARM: begin
          if (remote_init)    nxt = PS_INIT;
          else if (go_active) nxt = PS_ACTIVE;
        end
        PS_ACTIVE: if (remote_init) nxt = PS_INIT;
        default:   nxt = PS_DOWN;
      endcase
    end
  end
endmodule

// File: rtl/pls_arm_gate.sv
module pls_arm_gate
  import pls_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  pstate_e state,
  input  pstate_e nxt,
  input  logic    act_enable,
  input  logic    cmd_active,
  input  logic    act_trigger,
  output logic    go_active
);
  logic en_seen_q;
  logic req_seen_q;
  logic stay_arm;

  assign stay_arm  = (state == PS_ARM) && (nxt == PS_ARM);
  assign go_active = req_seen_q && act_trigger;

  always_ff @(posedge clk) begin
    if (rst || !stay_arm) begin
      en_seen_q  <= 1'b0;
      req_seen_q <= 1'b0;
    end else begin
      en_seen_q  <= en_seen_q | act_enable;
      req_seen_q <= req_seen_q | (cmd_active & en_seen_q);
    end
  end
endmodule

// File: rtl/pls_out_reg.sv
module pls_out_reg
  import pls_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  pstate_e nxt,
  output pstate_e state_q,
  output gate_t   gates_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_INIT;
      gates_q <= gates_for(PS_INIT);
    end else begin
      state_q <= nxt;
      gates_q <= gates_for(nxt);
    end
  end
endmodule

// File: rtl/port_state_ctrl.sv
module port_state_ctrl
  import pls_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               phy_up,
  input  logic               remote_init,
  input  logic [CMD_W-1:0]   mgmt_cmd,
  input  logic               act_enable,
  input  logic               act_trigger,
  input  logic               down_timeout,
  output logic               data_tx_en,
  output logic               data_rx_en,
  output logic               mgmt_en,
  output logic               lpkt_en,
  output logic [STATE_W-1:0] port_state
);
  mcmd_e   cmd;
  pstate_e state_q;
  pstate_e nxt;
  gate_t   gates_q;
  logic    go_active;

  assign cmd = mcmd_e'(mgmt_cmd);

  pls_next u_next (
    .state       (state_q),
    .phy_up      (phy_up),
    .remote_init (remote_init),
    .cmd         (cmd),
    .timeout     (down_timeout),
    .go_active   (go_active),
    .nxt         (nxt)
  );

  pls_arm_gate u_arm (
    .clk         (clk),
    .rst         (rst),
    .state       (state_q),
    .nxt         (nxt),
    .act_enable  (act_enable),
    .cmd_active  (cmd == MC_ACTIVE),
    .act_trigger (act_trigger),
    .go_active   (go_active)
  );

  pls_out_reg u_out (
    .clk     (clk),
    .rst     (rst),
    .nxt     (nxt),
    .state_q (state_q),
    .gates_q (gates_q)
  );

  assign port_state = state_q;
  assign data_tx_en = gates_q.data_tx;
  assign data_rx_en = gates_q.data_rx;
  assign mgmt_en    = gates_q.mgmt;
  assign lpkt_en    = gates_q.lpkt;
endmodule

// File: rtl/pls_checker.sv
module pls_checker (
  input logic       clk,
  input logic       rst,
  input logic       phy_up,
  input logic       remote_init,
  input logic [1:0] mgmt_cmd,
  input logic       act_enable,
  input logic       act_trigger,
  input logic       down_timeout,
  input logic       data_tx_en,
  input logic       data_rx_en,
  input logic       mgmt_en,
  input logic       lpkt_en,
  input logic [1:0] port_state
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d && !rst)
      p_reset_init_r1: assert (port_state == 2'd1 && mgmt_en && lpkt_en && !data_tx_en && !data_rx_en);
  end

  p_phy_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!phy_up && port_state == 2'd1) |=> (port_state == 2'd1 || port_state == 2'd0));

  p_cmd_down_r4: assert property (@(posedge clk) disable iff (rst)
    (mgmt_cmd == 2'd1) |=> (port_state == 2'd0));

  p_arm_to_active_r6: assert property (@(posedge clk) disable iff (rst)
    (port_state == 2'd3 && $past(port_state) != 2'd3) |-> ($past(port_state) == 2'd2 && $past(act_trigger)));

  p_timeout_down_r7: assert property (@(posedge clk) disable iff (rst)
    down_timeout |=> (port_state == 2'd0));

  p_gate_map_r9: assert property (@(posedge clk) disable iff (rst)
    (data_tx_en == (port_state == 2'd3)) && (data_rx_en == port_state[1]) &&
    (mgmt_en == (port_state != 2'd0)) && (lpkt_en == mgmt_en));
endmodule

bind port_state_ctrl pls_checker chk_i (
  .clk          (clk),
  .rst          (rst),
  .phy_up       (phy_up),
  .remote_init  (remote_init),
  .mgmt_cmd     (mgmt_cmd),
  .act_enable   (act_enable),
  .act_trigger  (act_trigger),
  .down_timeout (down_timeout),
  .data_tx_en   (data_tx_en),
  .data_rx_en   (data_rx_en),
  .mgmt_en      (mgmt_en),
  .lpkt_en      (lpkt_en),
  .port_state   (port_state)
);

// File: tb/port_state_ctrl_tb_top.sv
module port_state_ctrl_tb_top;
  localparam int RAND_STEPS = 4000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phy_up = 1'b0, remote_init = 1'b0, act_enable = 1'b0, act_trigger = 1'b0, down_timeout = 1'b0;
  logic [1:0] mgmt_cmd = 2'd0;
  logic data_tx_en, data_rx_en, mgmt_en, lpkt_en;
  logic [1:0] port_state;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [1:0] m_state = 2'd1;
  bit m_en = 1'b0, m_req = 1'b0;

  always #10 clk = ~clk;

  port_state_ctrl dut_i (
    .clk(clk), .rst(rst), .phy_up(phy_up), .remote_init(remote_init),
    .mgmt_cmd(mgmt_cmd), .act_enable(act_enable), .act_trigger(act_trigger),
    .down_timeout(down_timeout), .data_tx_en(data_tx_en), .data_rx_en(data_rx_en),
    .mgmt_en(mgmt_en), .lpkt_en(lpkt_en), .port_state(port_state)
  );

  // Expected gates {tx, rx, mgmt, link} per state code (R9).
  function automatic logic [3:0] exp_gates(logic [1:0] s);
    case (s)
      2'd0: return 4'b0000;
      2'd1: return 4'b0011;
      2'd2: return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [1:0] exp_next(logic [1:0] s, bit phy, bit ri, logic [1:0] c,
                                          bit trig, bit to, bit req);
    if (to) return 2'd0;
    if (c == 2'd1) return 2'd0;
    if (!phy) return (s == 2'd1) ? 2'd1 : 2'd0;
    case (s)
      2'd0: return 2'd1;
      2'd1: return (c == 2'd2) ? 2'd2 : 2'd1;
      2'd2: return ri ? 2'd1 : ((trig && req) ? 2'd3 : 2'd2);
      default: return ri ? 2'd1 : 2'd3;
    endcase
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (port_state !== m_state || {data_tx_en, data_rx_en, mgmt_en, lpkt_en} !== exp_gates(m_state)) begin
      errors++;
      $display("FAIL %s: state=%0d gates=%b expected state=%0d gates=%b", tag, port_state,
               {data_tx_en, data_rx_en, mgmt_en, lpkt_en}, m_state, exp_gates(m_state));
    end
  endtask

  task automatic step(input bit phy, input bit ri, input logic [1:0] c, input bit ae,
                      input bit at, input bit to, input string tag);
    logic [1:0] nx;
    phy_up = phy; remote_init = ri; mgmt_cmd = c; act_enable = ae; act_trigger = at; down_timeout = to;
    nx = exp_next(m_state, phy, ri, c, at, to, m_req);
    if (m_state == 2'd2 && nx == 2'd2) begin
      m_req = m_req | ((c == 2'd3) && m_en);
      m_en  = m_en | ae;
    end else begin
      m_en = 1'b0; m_req = 1'b0;
    end
    m_state = nx;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic reach_active();
    step(1, 0, 2'd1, 0, 0, 0, "R4");
    step(1, 0, 2'd0, 0, 0, 0, "R3");
    step(1, 0, 2'd2, 0, 0, 0, "R5");
    step(1, 0, 2'd0, 1, 0, 0, "R6");
    step(1, 0, 2'd3, 0, 0, 0, "R6");
    step(1, 0, 2'd0, 0, 1, 0, "R6");
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_state = 2'd1;
    compare("R1 reset");
    // R2: phy down holds Initialize even with Arm request
    step(0, 0, 2'd2, 0, 0, 0, "R2");
    // R5: Active request in Initialize is ignored
    step(1, 0, 2'd3, 0, 0, 0, "R5");
    // R4, R2, R3
    step(1, 0, 2'd1, 0, 0, 0, "R4");
    step(0, 0, 2'd0, 0, 0, 0, "R2");
    step(1, 0, 2'd0, 0, 0, 0, "R3");
    step(1, 0, 2'd2, 0, 0, 0, "R5");
    // R6: Active before enable ignored; trigger alone does nothing
    step(1, 0, 2'd3, 0, 0, 0, "R6");
    step(1, 0, 2'd0, 0, 1, 0, "R6");
    step(1, 0, 2'd0, 1, 0, 0, "R6");
    step(1, 0, 2'd0, 0, 1, 0, "R6");
    step(1, 0, 2'd3, 0, 0, 0, "R6");
    step(1, 0, 2'd0, 0, 1, 0, "R6");
    // R8: remote init from Active, then no effect in Initialize
    step(1, 1, 2'd0, 0, 0, 0, "R8");
    step(1, 1, 2'd0, 0, 0, 0, "R8");
    // R6: bookkeeping cleared on leaving Arm
    step(1, 0, 2'd2, 0, 0, 0, "R5");
    step(1, 0, 2'd0, 1, 0, 0, "R6");
    step(1, 0, 2'd3, 0, 0, 0, "R6");
    step(1, 1, 2'd0, 0, 0, 0, "R8");
    step(1, 0, 2'd2, 0, 0, 0, "R5");
    step(1, 0, 2'd0, 0, 1, 0, "R6");
    // R7: timeout outranks Arm request
    step(1, 0, 2'd2, 0, 0, 1, "R7");
    step(1, 0, 2'd0, 0, 0, 0, "R3");
    // R2: phy loss from Active
    reach_active();
    step(0, 0, 2'd0, 0, 0, 0, "R2");
    // R7 from Active
    reach_active();
    step(1, 1, 2'd0, 0, 1, 1, "R7");
    step(1, 0, 2'd0, 0, 0, 0, "R3");
    // R9: random mix
    for (int i = 0; i < RAND_STEPS; i++) begin
      bit phy, ri, ae, at, to;
      logic [1:0] c;
      int r;
      phy = ($urandom_range(0, 19) != 0);
      ri  = ($urandom_range(0, 29) == 0);
      ae  = ($urandom_range(0, 3) == 0);
      at  = ($urandom_range(0, 3) == 0);
      to  = ($urandom_range(0, 59) == 0);
      r = $urandom_range(0, 19);
      c = (r == 0) ? 2'd1 : (r < 5) ? 2'd2 : (r < 9) ? 2'd3 : 2'd0;
      step(phy, ri, c, ae, at, to, "R9 random");
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule